// File: doc/BRIEF.md
# Multicontext Reconfigurable Processing Element

This block is one coarse-grain processing element built around a 16-bit datapath. It holds eight complete configuration words in local registers. A context pointer picks the live word through a multiplexer. Each word sets the ALU operation, a shift amount, where each of the two ALU operands comes from (either input port, the element's own result register, or a 16-bit constant), and how the pointer moves on the next clock. Because all eight words are already on chip, the element can run a different configuration on every clock edge without any reload.

A host loads the words through a write port. A start pulse sets the pointer and sets the element running. From then on a small sequencer inside the word chooses the next context: it can go to a named context unconditionally, branch on a zero or negative ALU result, or stop. Each executed context writes its ALU result into one output register. The element has no internal data path apart from the feedback of that register.

Top module: `mc_pe`

## Requirements
- R1: After reset, `result` is 0, `ctx` is 0, `busy` is 0, and all eight context words are zero. An all-zero word means ADD with both operands taken from port A, condition "always", next context 0.
- R2: While `cfg_we` is high, `cfg_data` is stored in context `cfg_addr` at the clock edge. The word is packed as follows: opcode in bits [3:0], shift amount in [7:4], X-operand select in [9:8], Y-operand select in [11:10], condition in [13:12], next context in [16:14], and the immediate in [32:17].
- R3: Operand select codes are 0 for port A, 1 for port B, 2 for the current `result` register and 3 for the immediate field. These codes apply to both the X operand and the Y operand.
- R4: Opcode 0 gives X+Y and opcode 1 gives X-Y. Both wrap modulo 2^16.
- R5: Opcode 2 shifts X left by the shift amount. Opcode 3 shifts X right logically. Opcode 4 shifts X right arithmetically, copying the sign bit in.
- R6: Opcode 5 gives the absolute value of X. Opcode 6 gives the absolute value of the 16-bit difference X-Y. In both cases the negation wraps, so 0x8000 maps to 0x8000.
- R7: Opcodes 7 to 15 pass X through unchanged.
- R8: A `go` pulse, when `cfg_we` is low, loads `ctx` from `go_ctx` and sets `busy` on the next edge. `result` holds during that cycle.
- R9: Each clock in which `busy` is high and `cfg_we` is low, the active context executes and its ALU output is loaded into `result`. The next `ctx` is then chosen by the condition. Code 0 always takes the next-context field. Code 1 takes the next-context field if the ALU output is zero. Code 2 takes it if the ALU output's bit 15 is set. When the branch is not taken, `ctx` becomes ctx+1 modulo 8.
- R10: Condition code 3 executes the context once and then clears `busy`, leaving `ctx` unchanged. While `busy` is low, `result` and `ctx` hold.
- R11: While `cfg_we` is high, `result`, `ctx` and `busy` hold their values.
- R12: A write to the active context does not affect the cycle of the write. The new word is used from the next executed cycle onward.
- R13: Selecting the result register as an operand lets a context accumulate across consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable; also stalls execution |
| cfg_addr | input | 3 | Context index to write |
| cfg_data | input | 33 | Configuration word to write |
| go | input | 1 | Start pulse |
| go_ctx | input | 3 | Context loaded on a start pulse |
| a_in | input | 16 | Operand port A |
| b_in | input | 16 | Operand port B |
| result | output | 16 | Registered ALU result |
| ctx | output | 3 | Active context pointer |
| busy | output | 1 | Sequencer running |

## Verification
Each opcode is tried with operands chosen to expose a wrong variant. Wrap-around on add and subtract catches width errors. A value with both the top and bottom bits set distinguishes a logical right shift from an arithmetic one and shows what a left shift drops. Negative inputs and 0x8000 exercise the absolute-value paths. The branch conditions are each run once taken and once not taken, including the fall-through from context 7 to context 0. A feedback accumulation loop is stalled by configuration writes and then rewritten in place, which separates a correct stall and a correct in-place update from execution leaking through the write cycle.

// File: rtl/mc_pe.sv
module mc_pe #(
  parameter int W    = 16,
  parameter int NCTX = 8,
  parameter int OPW  = 4,
  parameter int SHW  = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [$clog2(NCTX)-1:0]                cfg_addr,
  input  logic [W+$clog2(NCTX)+6+SHW+OPW-1:0]    cfg_data,
  input  logic                                   go,
  input  logic [$clog2(NCTX)-1:0]                go_ctx,
  input  logic [W-1:0]                           a_in,
  input  logic [W-1:0]                           b_in,
  output logic [W-1:0]                           result,
  output logic [$clog2(NCTX)-1:0]                ctx,
  output logic                                   busy
);
  localparam int CXW   = $clog2(NCTX);
  localparam int CFGW  = W + CXW + 6 + SHW + OPW;
  localparam int SH_LO = OPW;
  localparam int SA_LO = SH_LO + SHW;
  localparam int SB_LO = SA_LO + 2;
  localparam int CD_LO = SB_LO + 2;
  localparam int NX_LO = CD_LO + 2;
  localparam int IM_LO = NX_LO + CXW;

  logic [CFGW-1:0] mem [NCTX];
  logic [CFGW-1:0] cur;
  logic [OPW-1:0]  op;
  logic [SHW-1:0]  sh;
  logic [1:0]      sela, selb, cond;
  logic [CXW-1:0]  nxt;
  logic [W-1:0]    imm, x, y, diff, alu;
  logic            take;

  assign cur  = mem[ctx];
  assign op   = cur[OPW-1:0];
  assign sh   = cur[SA_LO-1:SH_LO];
  assign sela = cur[SB_LO-1:SA_LO];
  assign selb = cur[CD_LO-1:SB_LO];
  assign cond = cur[NX_LO-1:CD_LO];
  assign nxt  = cur[IM_LO-1:NX_LO];
  assign imm  = cur[CFGW-1:IM_LO];

  function automatic logic [W-1:0] pick(input logic [1:0] s, input logic [W-1:0] a,
                                        input logic [W-1:0] b, input logic [W-1:0] f,
                                        input logic [W-1:0] i);
    case (s)
      2'd0:    pick = a;
      2'd1:    pick = b;
      2'd2:    pick = f;
      default: pick = i;
    endcase
  endfunction

  assign x    = pick(sela, a_in, b_in, result, imm);
  assign y    = pick(selb, a_in, b_in, result, imm);
  assign diff = x - y;

  always_comb begin
    case (op)
      4'd0:    alu = x + y;
      4'd1:    alu = diff;
      4'd2:    alu = x << sh;
      4'd3:    alu = x >> sh;
      4'd4:    alu = W'($signed(x) >>> sh);
      4'd5:    alu = x[W-1] ? -x : x;
      4'd6:    alu = diff[W-1] ? -diff : diff;
      default: alu = x;
    endcase
  end

  always_comb begin
    case (cond)
      2'd0:    take = 1'b1;
      2'd1:    take = (alu == '0);
      2'd2:    take = alu[W-1];
      default: take = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTX; i++) mem[i] <= '0;
    end else if (cfg_we) begin
      mem[cfg_addr] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      ctx    <= '0;
      busy   <= 1'b0;
    end else if (!cfg_we) begin
      if (go) begin
        ctx  <= go_ctx;
        busy <= 1'b1;
      end else if (busy) begin
        result <= alu;
        if (cond == 2'd3) busy <= 1'b0;
        else              ctx  <= take ? nxt : ctx + 1'b1;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (result == $past(result) && ctx == $past(ctx) && busy == $past(busy))); // R11
  AST_GO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !cfg_we) |=> (busy && ctx == $past(go_ctx) && result == $past(result))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go && !cfg_we) |=> (result == $past(result) && ctx == $past(ctx))); // R10
  AST_HALT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go && !cfg_we && cond == 2'd3) |=> (!busy && ctx == $past(ctx))); // R10
  AST_ALWAYS_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go && !cfg_we && cond == 2'd0) |=> (busy && ctx == $past(nxt))); // R9
endmodule

// File: tb/mc_pe_test.sv
module mc_pe_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [32:0] cfg_data = '0;
  logic        go = 1'b0;
  logic [2:0]  go_ctx = '0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] result;
  logic [2:0]  ctx;
  logic        busy;
  int errors = 0, checks = 0;

  mc_pe uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
             .cfg_data(cfg_data), .go(go), .go_ctx(go_ctx), .a_in(a_in), .b_in(b_in),
             .result(result), .ctx(ctx), .busy(busy));

  always #4 clk = ~clk;

  function automatic logic [32:0] cw(input int op, input int sh, input int sa, input int sb,
                                     input int cd, input int nx, input int imm);
    cw = {imm[15:0], nx[2:0], cd[1:0], sb[1:0], sa[1:0], sh[3:0], op[3:0]};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [32:0] d);
    cfg_we = 1'b1; cfg_addr = addr[2:0]; cfg_data = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic start(input int c);
    go = 1'b1; go_ctx = c[2:0];
    step();
    go = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 result", result, 0);
    chk("R1 ctx", ctx, 0);
    chk("R1 busy", busy, 0);
    a_in = 16'd5; b_in = 16'd7;
    start(3);
    chk("R8 ctx loaded", ctx, 3);
    chk("R8 result held", result, 0);
    step();
    chk("R1 zero word is A+A", result, 10);
    chk("R1 zero word next ctx", ctx, 0);
    wr(0, cw(0, 0, 0, 0, 3, 0, 0));
    step();
    chk("R10 halted", busy, 0);
  endtask

  task automatic t_op(input string tag, input int op, input int sh, input int a, input int b,
                      input int exp);
    wr(0, cw(op, sh, 0, 1, 3, 0, 0));
    a_in = a[15:0]; b_in = b[15:0];
    start(0);
    step();
    chk(tag, result, exp);
    chk({tag, " halt busy"}, busy, 0);
    step();
    chk({tag, " idle hold"}, result, exp);
  endtask

  task automatic t_sel();
    wr(4, cw(1, 0, 1, 3, 3, 0, 16'h0010));
    a_in = 16'h1111; b_in = 16'h0030;
    start(4);
    step();
    chk("R3 B minus imm", result, 16'h0020);
    wr(4, cw(0, 0, 2, 0, 3, 0, 0));
    a_in = 16'h0001;
    start(4);
    step();
    chk("R3 feedback plus A", result, 16'h0021);
  endtask

  task automatic t_cond();
    wr(2, cw(1, 0, 0, 1, 1, 5, 0));
    a_in = 9; b_in = 9;
    start(2); step();
    chk("R9 zero taken", ctx, 5);
    wr(2, cw(1, 0, 0, 1, 1, 5, 0));
    a_in = 9; b_in = 4;
    start(2); step();
    chk("R9 zero not taken", ctx, 3);
    wr(7, cw(1, 0, 0, 1, 2, 4, 0));
    a_in = 2; b_in = 6;
    start(7); step();
    chk("R9 neg taken", ctx, 4);
    wr(7, cw(1, 0, 0, 1, 2, 4, 0));
    a_in = 6; b_in = 2;
    start(7); step();
    chk("R9 neg not taken wraps", ctx, 0);
    wr(0, cw(0, 0, 0, 0, 3, 0, 0));
    step();
  endtask

  task automatic t_loop();
    wr(1, cw(0, 0, 2, 3, 0, 1, 3));
    wr(6, cw(5, 0, 1, 1, 3, 0, 0));
    a_in = 16'h0064; b_in = 16'h0000;
    start(6); step();
    chk("R6 abs of zero", result, 0);
    start(1);
    step(); step(); step();
    chk("R13 accumulate", result, 9);
    chk("R9 always stays", ctx, 1);
    cfg_we = 1'b1; cfg_addr = 3'd6; cfg_data = cw(0, 0, 0, 0, 3, 0, 0);
    step(); step(); step();
    chk("R11 stall result", result, 9);
    chk("R11 stall ctx", ctx, 1);
    chk("R11 stall busy", busy, 1);
    cfg_we = 1'b0;
    step();
    chk("R11 resume", result, 12);
    wr(1, cw(0, 0, 2, 3, 0, 1, 100));
    chk("R12 write cycle no exec", result, 12);
    step();
    chk("R12 new word used", result, 112);
    wr(1, cw(0, 0, 2, 3, 3, 1, 100));
    step();
    chk("R10 halt after rewrite", result, 212);
    chk("R10 busy cleared", busy, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    t_reset();
    t_op("R4 add wrap", 0, 0, 16'hFFFF, 2, 16'h0001);
    t_op("R4 sub wrap", 1, 0, 3, 5, 16'hFFFE);
    t_op("R5 shl", 2, 4, 16'h8001, 0, 16'h0010);
    t_op("R5 shr", 3, 4, 16'h8001, 0, 16'h0800);
    t_op("R5 sar", 4, 4, 16'h8001, 0, 16'hF800);
    t_op("R6 abs neg", 5, 0, 16'hFFF6, 0, 10);
    t_op("R6 abs min", 5, 0, 16'h8000, 0, 16'h8000);
    t_op("R6 absdiff", 6, 0, 3, 10, 7);
    t_op("R7 pass", 9, 3, 16'h1234, 16'h0F0F, 16'h1234);
    t_op("R2 full field", 15, 15, 16'hBEEF, 1, 16'hBEEF);
    t_sel();
    t_cond();
    t_loop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule